// File: doc/BRIEF.md
# Segmented DAC Row-Column Thermometer Encoder

This block turns a 12-bit converter sample into the switch drive for a segmented current-steering array. The four low-order bits stay binary and steer the binary-weighted cells. The eight high-order bits become a unary code for a field of 256 cell sites, arranged as 8 rows by 32 columns. Only 255 of those sites are ever used.

Each unary site works out its own state from two short codes. One is a row code taken from bits 6..4 and the other is a column code taken from bits 11..7. No central 8-to-255 decoder is used. The logical turn-on order is spread over the physical array by a fixed affine permutation, so that gradient errors do not pile up along one edge of the array.

The incoming word is registered first. After decoding, the binary and unary drives are registered again in one shared output stage, so both groups change on the same clock edge. Every control leaves the block as a true/complement pair from separate flops.

Top module: `dseg_thermo_enc`

## Requirements
- R1: `bin_on` equals bits 3..0 of the word presented on `code_in` two rising edges earlier.
- R2: The number of set bits in `cell_on` equals n, where n is the value of bits 11..4 of the word presented two rising edges earlier. n ranges from 0 to 255.
- R3: Take logical index k = 8*col + row. Logical cell k is on exactly when k < n. Raising n by one therefore adds exactly one active cell and removes none.
- R4: Logical index k drives physical bit (k*37 + 11) mod 256 of `cell_on`. This holds with the default parameters. The map is a bijection, so the 255 usable logical indices reach 255 distinct physical bits.
- R5: `bin_off` is always the bitwise inverse of `bin_on`, and `cell_off` is always the bitwise inverse of `cell_on`.
- R6: The latency from `code_in` to the outputs is exactly two cycles. After an input change, the binary and unary outputs both update on the same edge.
- R7: When `rst` is high at a rising edge, the next state is all cells off: `bin_on` = 0, `cell_on` = 0, and both complement outputs all ones. The first cycle after `rst` is released also shows this state.
- R8: Physical bit 230 of `cell_on` is the spare site that logical index 255 would drive. With the default parameters it is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Active-high synchronous reset |
| code_in | input | 12 | Converter sample; bits 3..0 binary, 6..4 row, 11..7 column |
| bin_on | output | 4 | Binary cell drive, true side |
| bin_off | output | 4 | Binary cell drive, complement side |
| cell_on | output | 256 | Unary cell drive by physical site, true side |
| cell_off | output | 256 | Unary cell drive by physical site, complement side |

## Verification
A fault in the row or column thermometer lines, or in a site's local neighbour test, shows up two cycles after the offending input. It appears either as a count on `cell_on` that differs from the code, or as a step where a change of one code does not add exactly one new site. A wrong placement shows as a site set at the wrong physical bit, or as a bit reached twice during a full code sweep. A stale input register shows one cycle too early or too late on both output groups together. A mismatched pair flop shows at once as `cell_off` or `bin_off` no longer being the inverse of its true side.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

    // Physical site reached by logical thermometer index k (affine scatter).
    function automatic int unsigned cell_place(
        input int unsigned k,
        input int unsigned mul,
        input int unsigned ofs,
        input int unsigned cells
    );
        return (k * mul + ofs) % cells;
    endfunction

endpackage

// File: rtl/dseg_in_reg.sv
module dseg_in_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/dseg_thermo_dec.sv
module dseg_thermo_dec #(
    parameter int CODE_W = 3,
    localparam int N = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [N-1:0]      lt
);
    // lt[i] is high for every line index below the code
    for (genvar i = 0; i < N; i++) begin : g_line
        assign lt[i] = (CODE_W'(i) < code);
    end
endmodule

// File: rtl/dseg_cell_matrix.sv
module dseg_cell_matrix #(
    parameter int ROWS     = 8,
    parameter int COLS     = 32,
    parameter int PERM_MUL = 37,
    parameter int PERM_OFS = 11,
    localparam int CELLS   = ROWS * COLS
) (
    input  logic [ROWS-1:0]  row_lt,
    input  logic [COLS-1:0]  col_lt,
    output logic [CELLS-1:0] phys_on
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic col_at;
        // column equals code: not below it, but left neighbour is below or c is 0
        if (c == 0) begin : g_first
            assign col_at = ~col_lt[c];
        end else begin : g_rest
            assign col_at = ~col_lt[c] & col_lt[c-1];
        end
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int unsigned K = c * ROWS + r;
            localparam int unsigned P = dseg_pkg::cell_place(K, PERM_MUL, PERM_OFS, CELLS);
            assign phys_on[P] = col_lt[c] | (col_at & row_lt[r]);
        end
    end
endmodule

// File: rtl/dseg_out_reg.sv
module dseg_out_reg #(
    parameter int BW = 4,
    parameter int UW = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] bin_d,
    input  logic [UW-1:0] una_d,
    output logic [BW-1:0] bin_on,
    output logic [BW-1:0] bin_off,
    output logic [UW-1:0] cell_on,
    output logic [UW-1:0] cell_off
);
    // true and complement sides held in separate flops, one shared edge
    always_ff @(posedge clk) begin
        if (rst) begin
            bin_on   <= '0;
            bin_off  <= '1;
            cell_on  <= '0;
            cell_off <= '1;
        end else begin
            bin_on   <= bin_d;
            bin_off  <= ~bin_d;
            cell_on  <= una_d;
            cell_off <= ~una_d;
        end
    end
endmodule

// File: rtl/dseg_thermo_enc.sv
module dseg_thermo_enc #(
    parameter int BIN_W    = 4,
    parameter int ROW_W    = 3,
    parameter int COL_W    = 5,
    parameter int PERM_MUL = 37,
    parameter int PERM_OFS = 11,
    localparam int IN_W    = BIN_W + ROW_W + COL_W,
    localparam int ROWS    = 1 << ROW_W,
    localparam int COLS    = 1 << COL_W,
    localparam int CELLS   = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  code_in,
    output logic [BIN_W-1:0] bin_on,
    output logic [BIN_W-1:0] bin_off,
    output logic [CELLS-1:0] cell_on,
    output logic [CELLS-1:0] cell_off
);
    logic [IN_W-1:0]  in_q;
    logic [ROWS-1:0]  row_lt;
    logic [COLS-1:0]  col_lt;
    logic [CELLS-1:0] una_d;

    dseg_in_reg #(.W(IN_W)) u_in (
        .clk (clk),
        .rst (rst),
        .d   (code_in),
        .q   (in_q)
    );

    dseg_thermo_dec #(.CODE_W(ROW_W)) u_row (
        .code (in_q[BIN_W+ROW_W-1:BIN_W]),
        .lt   (row_lt)
    );

    dseg_thermo_dec #(.CODE_W(COL_W)) u_col (
        .code (in_q[IN_W-1:BIN_W+ROW_W]),
        .lt   (col_lt)
    );

    dseg_cell_matrix #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .PERM_MUL (PERM_MUL),
        .PERM_OFS (PERM_OFS)
    ) u_mat (
        .row_lt  (row_lt),
        .col_lt  (col_lt),
        .phys_on (una_d)
    );

    dseg_out_reg #(.BW(BIN_W), .UW(CELLS)) u_out (
        .clk      (clk),
        .rst      (rst),
        .bin_d    (in_q[BIN_W-1:0]),
        .una_d    (una_d),
        .bin_on   (bin_on),
        .bin_off  (bin_off),
        .cell_on  (cell_on),
        .cell_off (cell_off)
    );
endmodule

// File: rtl/dseg_thermo_enc_chk.sv
module dseg_thermo_enc_chk #(
    parameter int BIN_W    = 4,
    parameter int ROW_W    = 3,
    parameter int COL_W    = 5,
    parameter int PERM_MUL = 37,
    parameter int PERM_OFS = 11,
    localparam int IN_W    = BIN_W + ROW_W + COL_W,
    localparam int CELLS   = (1 << ROW_W) * (1 << COL_W),
    localparam int unsigned SPARE =
        dseg_pkg::cell_place(CELLS - 1, PERM_MUL, PERM_OFS, CELLS)
) (
    input logic             clk,
    input logic             rst,
    input logic [IN_W-1:0]  code_in,
    input logic [BIN_W-1:0] bin_on,
    input logic [BIN_W-1:0] bin_off,
    input logic [CELLS-1:0] cell_on,
    input logic [CELLS-1:0] cell_off
);
    // number of edges since reset, saturating at 3
    logic [1:0] hist;
    always_ff @(posedge clk) begin
        if (rst)             hist <= '0;
        else if (hist != 2'd3) hist <= hist + 2'd1;
    end

    a_r1_bin_path: assert property (@(posedge clk) disable iff (rst)
        hist >= 2'd2 |-> bin_on == $past(code_in[BIN_W-1:0], 2));

    a_r2_cell_count: assert property (@(posedge clk) disable iff (rst)
        hist >= 2'd2 |-> $countones(cell_on) == int'($past(code_in[IN_W-1:BIN_W], 2)));

    a_r3_nested: assert property (@(posedge clk) disable iff (rst)
        (hist == 2'd3 &&
         $past(code_in[IN_W-1:BIN_W], 2) >= $past(code_in[IN_W-1:BIN_W], 3))
        |-> ((cell_on & $past(cell_on)) == $past(cell_on)));

    a_r5_pairs: assert property (@(posedge clk) disable iff (rst)
        cell_off == ~cell_on && bin_off == ~bin_on);

    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (cell_on == '0 && bin_on == '0 && cell_off == '1 && bin_off == '1));

    a_r8_spare_idle: assert property (@(posedge clk) disable iff (rst)
        !cell_on[SPARE]);
endmodule

bind dseg_thermo_enc dseg_thermo_enc_chk #(
    .BIN_W    (BIN_W),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .PERM_MUL (PERM_MUL),
    .PERM_OFS (PERM_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .code_in  (code_in),
    .bin_on   (bin_on),
    .bin_off  (bin_off),
    .cell_on  (cell_on),
    .cell_off (cell_off)
);

// File: tb/sim_dseg_thermo_enc.sv
module sim_dseg_thermo_enc;
    localparam int CLK_PERIOD = 10;
    localparam int CELLS = 256;
    localparam int MUL = 37;
    localparam int OFS = 11;
    localparam int SPARE_BIT = 230;
    localparam int NVEC = 11;
    // {input word, expected active unary count}
    localparam logic [20:0] VEC [NVEC] = '{
        {12'h000, 9'd0},   {12'hFFF, 9'd255}, {12'h00F, 9'd0},
        {12'h010, 9'd1},   {12'h01F, 9'd1},   {12'h0F5, 9'd15},
        {12'h100, 9'd16},  {12'h7A3, 9'd122}, {12'h800, 9'd128},
        {12'hA5C, 9'd165}, {12'hFF0, 9'd255}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [11:0]      code_in = '0;
    logic [3:0]       bin_on, bin_off;
    logic [CELLS-1:0] cell_on, cell_off;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dseg_thermo_enc u0 (
        .clk (clk), .rst (rst), .code_in (code_in),
        .bin_on (bin_on), .bin_off (bin_off),
        .cell_on (cell_on), .cell_off (cell_off)
    );

    // expected physical pattern for unary code n, from R3/R4
    function automatic logic [CELLS-1:0] want_cells(input int n);
        logic [CELLS-1:0] v = '0;
        for (int k = 0; k < n; k++) v[(k * MUL + OFS) % CELLS] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic apply(input logic [11:0] w);
        @(negedge clk);
        code_in = w;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_word(input logic [11:0] w, input string req);
        logic [CELLS-1:0] e;
        e = want_cells(int'(w[11:4]));
        check(bin_on == w[3:0], {req, "/R1 bin"},
              $sformatf("%h", bin_on), $sformatf("%h", w[3:0]));
        check(cell_on == e, {req, "/R4 cells"},
              $sformatf("%h", cell_on), $sformatf("%h", e));
        check(cell_off == ~cell_on && bin_off == ~bin_on, {req, "/R5 pairs"},
              $sformatf("%h", cell_off), $sformatf("%h", ~cell_on));
    endtask

    initial begin
        logic [CELLS-1:0] prev, seen, added;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(cell_on == '0 && bin_on == '0 && cell_off == '1 && bin_off == '1, "R7 reset",
              $sformatf("%h/%h", cell_on, bin_on), "0/0");
        rst = 1'b0;

        // table walk, R2 count per vector
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][20:9]);
            check($countones(cell_on) == int'(VEC[i][8:0]), "R2 count",
                  $sformatf("%0d", $countones(cell_on)), $sformatf("%0d", VEC[i][8:0]));
            check_word(VEC[i][20:9], "R2");
        end

        // full sweep: R3 single-step growth, R4 bijection, R8 spare
        apply(12'h000);
        prev = cell_on;
        seen = '0;
        for (int n = 1; n < 256; n++) begin
            apply({n[7:0], n[3:0]});
            added = cell_on & ~prev;
            check($countones(added) == 1 && (prev & ~cell_on) == '0, "R3 step",
                  $sformatf("%0d", $countones(added)), "1");
            check((seen & added) == '0, "R4 distinct",
                  $sformatf("%h", seen & added), "0");
            check_word({n[7:0], n[3:0]}, "R3");
            seen = seen | added;
            prev = cell_on;
        end
        check($countones(seen) == 255 && !seen[SPARE_BIT], "R4 bijection",
              $sformatf("%0d", $countones(seen)), "255");
        check(!cell_on[SPARE_BIT], "R8 spare", $sformatf("%b", cell_on[SPARE_BIT]), "0");

        // R6: latency two cycles, both groups together
        apply(12'h000);
        @(negedge clk);
        code_in = 12'hFFF;
        @(negedge clk);
        check(cell_on == '0 && bin_on == 4'h0, "R6 early",
              $sformatf("%0d/%h", $countones(cell_on), bin_on), "0/0");
        @(negedge clk);
        check($countones(cell_on) == 255 && bin_on == 4'hF, "R6 aligned",
              $sformatf("%0d/%h", $countones(cell_on), bin_on), "255/f");

        // R7: reset in mid-stream, then release
        rst = 1'b1;
        @(negedge clk);
        check(cell_on == '0 && bin_on == '0 && cell_off == '1 && bin_off == '1, "R7 mid reset",
              $sformatf("%0d/%h", $countones(cell_on), bin_on), "0/0");
        rst = 1'b0;
        @(negedge clk);
        check(cell_on == '0 && bin_on == '0, "R7 first after release",
              $sformatf("%0d/%h", $countones(cell_on), bin_on), "0/0");
        @(negedge clk);
        check_word(12'hFFF, "R7 resume");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule